// File: doc/BRIEF.md
# Path-Coloring Reconvergence Point Detector

This block learns where the two outcome paths of one conditional branch join again. It watches the stream of retired instructions. Each time the watched branch retires, the block opens a marking window for that instance and gives it a path color, taken or not-taken. The PCs that retire inside the window are written into a small content-addressed table. Each table entry holds one color bit per path. The first PC that ends up holding both colors is the reconvergence point. The block latches it and reports it.

Software or a neighbouring predictor loads the branch PC to study. The block then needs at least one retired instance in each direction. A return inside a window is recorded by its target and not by its own PC, so two paths that leave the function meet at the return target. The table is small. A window that would overflow it throws the attempt away, and learning starts again with the next instance.

Top module: `rcv_detect`

## Requirements
- R1: After reset, rcv_valid_o is 0.
- R2: Inside a window, each retired PC is marked with that window's color: taken when ret_taken_i was 1 on the opening instance, not-taken otherwise. The first PC whose entry completes both colors is reported on rcv_pc_o.
- R3: rcv_valid_o and rcv_pc_o change on the clock edge that retires the instruction completing the second color. Nothing is reported before that edge.
- R4: No result is reported while the watched branch has retired in only one direction.
- R5: A retired return (ret_is_ret_i=1) inside a window marks ret_tgt_i in place of its own PC and closes the window. Instructions retired after it are not marked.
- R6: A window marks at most WIN_LEN (32) retired instructions. The 33rd and later are not marked.
- R7: A retired branch (ret_is_br_i=1) whose PC equals the watched PC is an instance. It is not marked itself. It closes any open window and opens a new one with its own color.
- R8: When a PC misses and all CAM_DEPTH (16) entries are in use, every entry is cleared and the window closes. Colors marked before that point no longer count.
- R9: Once rcv_valid_o is 1, it and rcv_pc_o stay unchanged, whatever retires, until the next watch load.
- R10: watch_load_i=1 clears the table, any open window and the result, and latches watch_pc_i. A retire in the same cycle is ignored.
- R11: When ret_valid_i is 0, the retire fields are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| watch_load_i | input | 1 | Load a new branch to watch and restart learning |
| watch_pc_i | input | PC_W | PC of the branch to watch, sampled on watch_load_i |
| ret_valid_i | input | 1 | An instruction retires this cycle |
| ret_pc_i | input | PC_W | PC of the retired instruction |
| ret_is_br_i | input | 1 | Retired instruction is a conditional branch |
| ret_taken_i | input | 1 | Direction of the retired branch |
| ret_is_ret_i | input | 1 | Retired instruction is a return |
| ret_tgt_i | input | PC_W | Target of the retired return |
| rcv_valid_o | output | 1 | Reconvergence point learned |
| rcv_pc_o | output | PC_W | Learned reconvergence PC |

## Verification
Every result is registered once. A retire presented before edge N shows up on the outputs right after edge N. The bench drives inputs on the falling edge, steps a bench-side model at the rising edge, and compares both outputs on the next falling edge. In that way every retire is checked in the single cycle it is due. The directed cases also check the outputs one retire before the completing PC, so an early report would show up as a miscompare.

// File: rtl/rcv_pkg.sv
package rcv_pkg;
  localparam int unsigned DEF_PC_W  = 32;
  localparam int unsigned DEF_DEPTH = 16;
  localparam int unsigned DEF_WIN   = 32;

  typedef enum logic {
    COL_NT = 1'b0,
    COL_TK = 1'b1
  } color_e;
endpackage

// File: rtl/rcv_cam.sv
module rcv_cam
  import rcv_pkg::*;
#(
  parameter int unsigned PC_W  = DEF_PC_W,
  parameter int unsigned DEPTH = DEF_DEPTH
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            mark_i,
  input  color_e          color_i,
  input  logic [PC_W-1:0] pc_i,
  output logic            meet_o,
  output logic            full_miss_o
);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [DEPTH-1:0] ent_v_q;
  logic [DEPTH-1:0] col_tk_q;
  logic [DEPTH-1:0] col_nt_q;
  logic [PC_W-1:0]  ent_pc_q [DEPTH];
  logic [CNT_W-1:0] fill_q;
  logic [DEPTH-1:0] hit_vec;
  logic             hit;
  logic             full;
  logic             alloc;

  assign hit   = |hit_vec;
  assign full  = (fill_q == CNT_W'(DEPTH));
  assign alloc = mark_i && !hit && !full && !clr_i;

  // meet: entry already carries the opposite color
  assign meet_o      = mark_i && |(hit_vec & ((color_i == COL_TK) ? col_nt_q : col_tk_q));
  assign full_miss_o = mark_i && !hit && full;

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    assign hit_vec[g] = ent_v_q[g] && (ent_pc_q[g] == pc_i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ent_v_q[g]  <= 1'b0;
        col_tk_q[g] <= 1'b0;
        col_nt_q[g] <= 1'b0;
        ent_pc_q[g] <= '0;
      end else if (clr_i) begin
        ent_v_q[g]  <= 1'b0;
        col_tk_q[g] <= 1'b0;
        col_nt_q[g] <= 1'b0;
      end else if (mark_i && hit_vec[g]) begin
        if (color_i == COL_TK) col_tk_q[g] <= 1'b1;
        else                   col_nt_q[g] <= 1'b1;
      end else if (alloc && (fill_q == CNT_W'(g))) begin
        ent_v_q[g]  <= 1'b1;
        ent_pc_q[g] <= pc_i;
        col_tk_q[g] <= (color_i == COL_TK);
        col_nt_q[g] <= (color_i == COL_NT);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    fill_q <= '0;
    else if (clr_i) fill_q <= '0;
    else if (alloc) fill_q <= fill_q + CNT_W'(1);
  end
endmodule

// File: rtl/rcv_window.sv
module rcv_window
  import rcv_pkg::*;
#(
  parameter int unsigned WIN = DEF_WIN
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   start_i,
  input  color_e start_col_i,
  input  logic   step_i,
  input  logic   stop_i,
  output logic   active_o,
  output color_e col_o
);
  localparam int unsigned CNT_W = $clog2(WIN + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o <= 1'b0;
      col_o    <= COL_NT;
      cnt_q    <= '0;
    end else if (start_i) begin
      active_o <= 1'b1;
      col_o    <= start_col_i;
      cnt_q    <= '0;
    end else if (stop_i) begin
      active_o <= 1'b0;
    end else if (step_i) begin
      if (cnt_q == CNT_W'(WIN - 1)) active_o <= 1'b0;
      else                          cnt_q    <= cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/rcv_detect.sv
module rcv_detect
  import rcv_pkg::*;
#(
  parameter int unsigned PC_W      = DEF_PC_W,
  parameter int unsigned CAM_DEPTH = DEF_DEPTH,
  parameter int unsigned WIN_LEN   = DEF_WIN
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            watch_load_i,
  input  logic [PC_W-1:0] watch_pc_i,
  input  logic            ret_valid_i,
  input  logic [PC_W-1:0] ret_pc_i,
  input  logic            ret_is_br_i,
  input  logic            ret_taken_i,
  input  logic            ret_is_ret_i,
  input  logic [PC_W-1:0] ret_tgt_i,
  output logic            rcv_valid_o,
  output logic [PC_W-1:0] rcv_pc_o
);
  logic [PC_W-1:0] watch_q;
  logic            is_inst;
  logic            live;
  logic            start;
  logic            step;
  logic            stop;
  logic            meet;
  logic            full_miss;
  logic            cam_clr;
  logic            win_active;
  color_e          win_col;
  color_e          inst_col;
  logic [PC_W-1:0] mark_pc;

  assign live     = ret_valid_i && !watch_load_i && !rcv_valid_o;
  assign is_inst  = ret_is_br_i && (ret_pc_i == watch_q);
  assign inst_col = ret_taken_i ? COL_TK : COL_NT;
  assign start    = live && is_inst;
  assign step     = live && !is_inst && win_active;
  assign mark_pc  = ret_is_ret_i ? ret_tgt_i : ret_pc_i;
  assign stop     = watch_load_i || (step && (meet || full_miss || ret_is_ret_i));
  assign cam_clr  = watch_load_i || full_miss;

  rcv_window #(.WIN(WIN_LEN)) u_win (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .start_col_i(inst_col),
    .step_i     (step),
    .stop_i     (stop),
    .active_o   (win_active),
    .col_o      (win_col)
  );

  rcv_cam #(.PC_W(PC_W), .DEPTH(CAM_DEPTH)) u_cam (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (cam_clr),
    .mark_i     (step),
    .color_i    (win_col),
    .pc_i       (mark_pc),
    .meet_o     (meet),
    .full_miss_o(full_miss)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      watch_q     <= '0;
      rcv_valid_o <= 1'b0;
      rcv_pc_o    <= '0;
    end else if (watch_load_i) begin
      watch_q     <= watch_pc_i;
      rcv_valid_o <= 1'b0;
    end else if (step && meet) begin
      rcv_valid_o <= 1'b1;
      rcv_pc_o    <= mark_pc;
    end
  end
endmodule

// File: rtl/rcv_detect_chk.sv
module rcv_detect_chk #(
  parameter int unsigned PC_W = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            watch_load_i,
  input logic            ret_valid_i,
  input logic [PC_W-1:0] ret_pc_i,
  input logic            ret_is_ret_i,
  input logic [PC_W-1:0] ret_tgt_i,
  input logic            rcv_valid_o,
  input logic [PC_W-1:0] rcv_pc_o
);
  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rcv_valid_o && !watch_load_i) |=> (rcv_valid_o && $stable(rcv_pc_o)));

  a_r10_load_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    watch_load_i |=> !rcv_valid_o);

  a_r3_rise_on_retire: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rcv_valid_o) |-> ($past(ret_valid_i) && !$past(watch_load_i)));

  a_r2_pc_from_stream: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rcv_valid_o) |-> (rcv_pc_o == $past(ret_is_ret_i ? ret_tgt_i : ret_pc_i)));

  a_r11_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ret_valid_i && !watch_load_i) |=> $stable(rcv_valid_o));
endmodule

bind rcv_detect rcv_detect_chk #(.PC_W(PC_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .watch_load_i(watch_load_i),
  .ret_valid_i (ret_valid_i),
  .ret_pc_i    (ret_pc_i),
  .ret_is_ret_i(ret_is_ret_i),
  .ret_tgt_i   (ret_tgt_i),
  .rcv_valid_o (rcv_valid_o),
  .rcv_pc_o    (rcv_pc_o)
);

// File: tb/rcv_detect_test.sv
module rcv_detect_test;
  localparam int PC_W = 32;
  localparam int DEPTH = 16;
  localparam int WIN = 32;
  localparam logic [31:0] W = 32'h100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld = 1'b0;
  logic [31:0] wpc = '0;
  logic v = 1'b0, br = 1'b0, tk = 1'b0, rt = 1'b0;
  logic [31:0] pc = '0, tgt = '0;
  logic rvalid;
  logic [31:0] rpc;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  rcv_detect uut (
    .clk_i(clk), .rst_ni(rst_n), .watch_load_i(ld), .watch_pc_i(wpc),
    .ret_valid_i(v), .ret_pc_i(pc), .ret_is_br_i(br), .ret_taken_i(tk),
    .ret_is_ret_i(rt), .ret_tgt_i(tgt), .rcv_valid_o(rvalid), .rcv_pc_o(rpc)
  );

  // bench model
  bit          m_v [DEPTH];
  bit          m_t [DEPTH];
  bit          m_n [DEPTH];
  logic [31:0] m_pc [DEPTH];
  int          m_fill = 0;
  bit          m_act = 0;
  bit          m_col = 0;
  int          m_cnt = 0;
  bit          m_found = 0;
  logic [31:0] m_rpc = '0;
  logic [31:0] m_watch = '0;

  task automatic m_clear();
    for (int i = 0; i < DEPTH; i++) begin m_v[i] = 0; m_t[i] = 0; m_n[i] = 0; end
    m_fill = 0;
  endtask

  task automatic m_step();
    logic [31:0] mp;
    int hi;
    bit stopw;
    if (ld) begin
      m_clear(); m_act = 0; m_found = 0; m_watch = wpc;
    end else if (v && !m_found) begin
      if (br && pc == m_watch) begin
        m_act = 1; m_col = tk; m_cnt = 0;
      end else if (m_act) begin
        mp = rt ? tgt : pc;
        hi = -1;
        stopw = rt;
        for (int i = 0; i < DEPTH; i++) if (m_v[i] && m_pc[i] == mp) hi = i;
        if (hi >= 0) begin
          if (m_col ? m_n[hi] : m_t[hi]) begin
            m_found = 1; m_rpc = mp; stopw = 1;
          end
          if (m_col) m_t[hi] = 1; else m_n[hi] = 1;
        end else if (m_fill < DEPTH) begin
          m_v[m_fill] = 1; m_pc[m_fill] = mp; m_t[m_fill] = m_col; m_n[m_fill] = !m_col;
          m_fill++;
        end else begin
          m_clear(); stopw = 1;
        end
        if (stopw) m_act = 0;
        else if (m_cnt == WIN - 1) m_act = 0;
        else m_cnt++;
      end
    end
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one cycle: drive at negedge, model at posedge, compare at next negedge
  task automatic cyc(bit l, logic [31:0] w, bit vv, logic [31:0] p, bit b, bit t, bit r, logic [31:0] g);
    ld = l; wpc = w; v = vv; pc = p; br = b; tk = t; rt = r; tgt = g;
    @(posedge clk);
    m_step();
    @(negedge clk);
    chk("model-valid", {31'b0, rvalid}, {31'b0, m_found});
    if (m_found) chk("model-pc", rpc, m_rpc);
    ld = 0; v = 0;
  endtask

  task automatic load(logic [31:0] w); cyc(1, w, 0, 0, 0, 0, 0, 0); endtask
  task automatic bi(bit t);            cyc(0, wpc, 1, W, 1, t, 0, 0); endtask
  task automatic ins(logic [31:0] p);  cyc(0, wpc, 1, p, 0, 0, 0, 0); endtask
  task automatic rtn(logic [31:0] p, logic [31:0] g); cyc(0, wpc, 1, p, 0, 0, 1, g); endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    m_clear();
    repeat (3) @(negedge clk);
    chk("R1 reset valid", {31'b0, rvalid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R3 R7
    load(W);
    bi(1); ins(32'h200); ins(32'h204);
    bi(0); ins(32'h208);
    chk("R3 not early", {31'b0, rvalid}, 32'd0);
    ins(32'h204);
    chk("R2 valid", {31'b0, rvalid}, 32'd1);
    chk("R2 pc", rpc, 32'h204);
    // R9
    bi(0); ins(32'h200); bi(1); ins(32'h208); ins(32'h300);
    chk("R9 hold valid", {31'b0, rvalid}, 32'd1);
    chk("R9 hold pc", rpc, 32'h204);

    // R7 same-direction instances only, then flip
    load(W);
    chk("R10 load clears", {31'b0, rvalid}, 32'd0);
    bi(1); ins(32'h200); bi(1); ins(32'h200);
    chk("R4 one direction", {31'b0, rvalid}, 32'd0);
    bi(0); ins(32'h200);
    chk("R7 new window", rpc, 32'h200);

    // R5 returns
    load(W);
    bi(1); ins(32'h210); rtn(32'h220, 32'h400); ins(32'h230);
    bi(0); ins(32'h240); ins(32'h230);
    chk("R5 window closed at return", {31'b0, rvalid}, 32'd0);
    rtn(32'h250, 32'h400);
    chk("R5 target valid", {31'b0, rvalid}, 32'd1);
    chk("R5 target pc", rpc, 32'h400);

    // R6 window length
    load(W);
    bi(1);
    for (int i = 0; i < WIN - 1; i++) ins(32'h500);
    ins(32'h504); ins(32'h508);
    bi(0); ins(32'h508);
    chk("R6 33rd unmarked", {31'b0, rvalid}, 32'd0);
    ins(32'h504);
    chk("R6 32nd marked", rpc, 32'h504);

    // R8 overflow
    load(W);
    bi(1);
    for (int i = 0; i <= DEPTH; i++) ins(32'h600 + 32'(4 * i));
    bi(0); ins(32'h600);
    chk("R8 cleared", {31'b0, rvalid}, 32'd0);
    bi(1); ins(32'h600);
    chk("R8 restart pc", rpc, 32'h600);
    chk("R8 restart valid", {31'b0, rvalid}, 32'd1);

    // R10 retire in load cycle ignored
    cyc(1, W, 1, W, 1, 1, 0, 0);
    ins(32'h700); bi(0); ins(32'h700);
    chk("R10 same-cycle retire ignored", {31'b0, rvalid}, 32'd0);

    // R11 invalid retire ignored
    load(W);
    cyc(0, W, 0, W, 1, 1, 0, 0);
    ins(32'h710); bi(0); ins(32'h710);
    chk("R11 invalid ignored", {31'b0, rvalid}, 32'd0);

    // random phase
    void'($urandom(32'd1234));
    load(W);
    for (int n = 0; n < 4000; n++) begin
      int r;
      r = int'($urandom_range(0, 99));
      if (r < 1) load(W);
      else if (r < 15) bi(1'($urandom_range(0, 1)));
      else if (r < 20) rtn(32'h800 + 32'(4 * $urandom_range(0, 7)), 32'h900 + 32'(4 * $urandom_range(0, 3)));
      else if (r < 25) cyc(0, wpc, 0, 32'h200, 0, 0, 0, 0);
      else ins(32'h200 + 32'(4 * $urandom_range(0, 19)));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule